// File: doc/BRIEF.md
# Column-Aware March Memory Self-Test Engine

This block is a built-in self-test engine for a small synchronous single-port SRAM. The array is organised as ROWS rows of COLS words. The engine runs one fixed March-style algorithm. The algorithm is a classic March C pass followed by a short tail of elements aimed at half-select stability faults. In such a fault, writing one column of a row disturbs the unselected cells sharing that row. Some elements sweep every address. Others visit only the even columns or only the odd columns, and the address generator steps straight over the cells it should not touch.

A pulse on `start` launches a test. The engine then drives the memory enables, the address and the write data, one operation per clock. Read data arrives one cycle after the read is issued and is compared against the value the algorithm expects. The first mismatch stops the test at once and records the failing address and the element number. A clean run ends with `done` high and `fail` low. The total number of memory operations is 12N−2R, where N = ROWS·COLS and R = ROWS.

Top module: `colmarch_bist`

## Requirements
- R1: While reset is low at a clock edge, the engine goes idle. After that edge `mem_en`, `done` and `fail` are low, and they stay low until the next `start`.
- R2: The elements run in index order, numbered 0 to 8:
  - 0: ascending, all cells, write 0.
  - 1: ascending, all cells, read 0 then write 1.
  - 2: ascending, all cells, read 1 then write 0.
  - 3: descending, all cells, read 0 then write 1.
  - 4: descending, all cells, read 1 then write 0.
  - 5: ascending, even columns, write 1 then read 1.
  - 6: ascending, inner odd columns, read 0.
  - 7: ascending, odd columns, write 1 then read 1.
  - 8: ascending, inner even columns, read 1.
- R3: The address is {row, col}, so the column index is the low log2(COLS) bits. A column is even when its LSB is 0. Inner odd columns exclude column COLS−1, and inner even columns exclude column 0. Ascending order runs from address 0 upward and descending order runs downward. Cells outside an element's filter take no cycle.
- R4: A fault-free run issues exactly 12N−2R operations on consecutive clock cycles, with `mem_en` high for each of them.
- R5: Read data is compared one cycle after its read. On a clean run, `done` is first high after the edge that is (operations + 1) edges after the edge sampling `start`, and `fail` stays low.
- R6: On the first read whose data differs from the expected word, no further operation is issued. `fail` is set, `fail_addr` holds that read's address and `fail_elem` holds its element index. `done` is first high one edge after the mismatching data is presented.
- R7: A `start` pulse during a running test has no effect on the operation count or the completion time.
- R8: A `start` while `done` is high begins a new test, clearing `fail`, `fail_addr` and `fail_elem`.
- R9: A write drives all bits of `mem_wdata` to the written value, either all zeros or all ones. A read keeps `mem_we` low with `mem_en` high.
- R10: Without `start`, `done`, `fail`, `fail_addr` and `fail_elem` hold their values after a test ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test when idle or finished |
| mem_rdata | input | DW | Read data from the memory, valid one cycle after a read |
| mem_en | output | 1 | Memory operation enable |
| mem_we | output | 1 | Write enable (read when low with `mem_en` high) |
| mem_addr | output | log2(ROWS)+log2(COLS) | Memory address {row, col} |
| mem_wdata | output | DW | Write data, all zeros or all ones |
| done | output | 1 | Test finished |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | log2(ROWS)+log2(COLS) | Address of the first failing read |
| fail_elem | output | 4 | Element index of the first failing read |

## Verification
The first operation appears in the cycle right after the edge that samples `start`. Each read's data is judged one edge later. `done` therefore rises exactly (operations + 1) edges after the start edge, both on a clean run and when the failing read was the k-th operation. The bench holds `start` for one edge, then counts edges one at a time and looks at the outputs on the falling edge after each rising edge. It compares that count with the reference model's operation count plus one. The per-operation trace is captured at the same rising edges the memory model uses, and a reset's effect is checked on the falling edge just after the edge that sampled it.

// File: rtl/colmarch_pkg.sv
`timescale 1ns/1ps
// colmarch_pkg: shared types and the element descriptor table of the
// column-aware March self-test engine.
// Assumes: element count fixed at nine; ops encode {is_read, data_bit}.
package colmarch_pkg;

    localparam int NUM_ELEMS = 9;
    localparam int ELEM_W    = 4;

    // Column filter applied by the address generator
    typedef enum logic [2:0] {
        FLT_ALL     = 3'd0,
        FLT_EVEN    = 3'd1,
        FLT_ODD     = 3'd2,
        FLT_EVEN_IN = 3'd3,
        FLT_ODD_IN  = 3'd4
    } flt_e;

    // Memory operation: bit1 = read, bit0 = data value
    typedef enum logic [1:0] {
        OP_W0 = 2'b00,
        OP_W1 = 2'b01,
        OP_R0 = 2'b10,
        OP_R1 = 2'b11
    } op_e;

    typedef struct packed {
        logic down;   // descending address order
        flt_e flt;    // column filter
        logic two;    // two operations per cell
        op_e  op_a;   // first operation
        op_e  op_b;   // second operation (used when two)
    } elem_t;

    // Descriptor table lookup, one entry per element
    function automatic elem_t elem_rom(input logic [ELEM_W-1:0] idx);
        elem_t d;
        case (idx)
            4'd0:    d = '{down: 1'b0, flt: FLT_ALL,     two: 1'b0, op_a: OP_W0, op_b: OP_W0};
            4'd1:    d = '{down: 1'b0, flt: FLT_ALL,     two: 1'b1, op_a: OP_R0, op_b: OP_W1};
            4'd2:    d = '{down: 1'b0, flt: FLT_ALL,     two: 1'b1, op_a: OP_R1, op_b: OP_W0};
            4'd3:    d = '{down: 1'b1, flt: FLT_ALL,     two: 1'b1, op_a: OP_R0, op_b: OP_W1};
            4'd4:    d = '{down: 1'b1, flt: FLT_ALL,     two: 1'b1, op_a: OP_R1, op_b: OP_W0};
            4'd5:    d = '{down: 1'b0, flt: FLT_EVEN,    two: 1'b1, op_a: OP_W1, op_b: OP_R1};
            4'd6:    d = '{down: 1'b0, flt: FLT_ODD_IN,  two: 1'b0, op_a: OP_R0, op_b: OP_R0};
            4'd7:    d = '{down: 1'b0, flt: FLT_ODD,     two: 1'b1, op_a: OP_W1, op_b: OP_R1};
            default: d = '{down: 1'b0, flt: FLT_EVEN_IN, two: 1'b0, op_a: OP_R1, op_b: OP_R1};
        endcase
        return d;
    endfunction

    function automatic logic op_is_rd(input op_e o);
        return o[1];
    endfunction

    function automatic logic op_val(input op_e o);
        return o[0];
    endfunction

endpackage

// File: rtl/colmarch_addr_gen.sv
`timescale 1ns/1ps
// colmarch_addr_gen: walks the {row, col} address space for one element,
// visiting only the columns its filter admits, one address per step.
// Assumes: ROWS >= 2 and COLS >= 4, both powers of two; load and step are
// never high together.
module colmarch_addr_gen
    import colmarch_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int AW  = RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          ld_down,
    input  flt_e          ld_flt,
    output logic [AW-1:0] addr,
    output logic          last
);

    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          down_q;
    flt_e          flt_q;
    logic [CW-1:0] lo_c;
    logic [CW-1:0] hi_c;
    logic [CW-1:0] st_c;

    // Lowest column admitted by a filter
    function automatic logic [CW-1:0] col_lo(input flt_e f);
        case (f)
            FLT_ODD, FLT_ODD_IN: return CW'(1);
            FLT_EVEN_IN:         return CW'(2);
            default:             return CW'(0);
        endcase
    endfunction

    // Highest column admitted by a filter
    function automatic logic [CW-1:0] col_hi(input flt_e f);
        case (f)
            FLT_EVEN, FLT_EVEN_IN: return CW'(COLS - 2);
            FLT_ODD_IN:            return CW'(COLS - 3);
            default:               return CW'(COLS - 1);
        endcase
    endfunction

    // Column stride of a filter
    function automatic logic [CW-1:0] col_st(input flt_e f);
        return (f == FLT_ALL) ? CW'(1) : CW'(2);
    endfunction

    // Column window of the active element
    always_comb begin
        lo_c = col_lo(flt_q);
        hi_c = col_hi(flt_q);
        st_c = col_st(flt_q);
    end

    // Position register: load at element entry, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            down_q <= 1'b0;
            flt_q  <= FLT_ALL;
        end else if (load) begin
            down_q <= ld_down;
            flt_q  <= ld_flt;
            row_q  <= ld_down ? ROW_MAX : '0;
            col_q  <= ld_down ? col_hi(ld_flt) : col_lo(ld_flt);
        end else if (step) begin
            if (!down_q) begin
                if (col_q == hi_c) begin
                    col_q <= lo_c;
                    row_q <= row_q + RW'(1);
                end else begin
                    col_q <= col_q + st_c;
                end
            end else begin
                if (col_q == lo_c) begin
                    col_q <= hi_c;
                    row_q <= row_q - RW'(1);
                end else begin
                    col_q <= col_q - st_c;
                end
            end
        end
    end

    // Address and end-of-element flag
    always_comb begin
        addr = {row_q, col_q};
        last = down_q ? (row_q == '0 && col_q == lo_c)
                      : (row_q == ROW_MAX && col_q == hi_c);
    end

    // The column never leaves the window of the active filter
    p_col_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q >= col_lo(flt_q)) && (col_q <= col_hi(flt_q)));

endmodule

// File: rtl/colmarch_cmp.sv
`timescale 1ns/1ps
// colmarch_cmp: carries the expected value, address and element of each
// read for one cycle and compares it with the returning read data.
// Assumes: the memory returns read data exactly one cycle after the read.
module colmarch_cmp
    import colmarch_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              rd_exp,
    input  logic [AW-1:0]     rd_addr,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic [DW-1:0]     rdata,
    output logic              mismatch,
    output logic [AW-1:0]     mis_addr,
    output logic [ELEM_W-1:0] mis_elem
);

    logic              pend_q;
    logic              exp_q;
    logic [AW-1:0]     addr_q;
    logic [ELEM_W-1:0] elem_q;

    // Pipe the read's context alongside the memory latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            exp_q  <= 1'b0;
            addr_q <= '0;
            elem_q <= '0;
        end else begin
            pend_q <= rd_issue;
            if (rd_issue) begin
                exp_q  <= rd_exp;
                addr_q <= rd_addr;
                elem_q <= rd_elem;
            end
        end
    end

    // Word compare against the replicated expected bit
    always_comb begin
        mismatch = pend_q && (rdata != {DW{exp_q}});
        mis_addr = addr_q;
        mis_elem = elem_q;
    end

endmodule

// File: rtl/colmarch_seq.sv
`timescale 1ns/1ps
// colmarch_seq: test sequencer. Steps through the element table, issues
// one memory operation per cycle, steers the address generator and
// records the first failure.
// Assumes: compare result arrives one cycle after each read; a mismatch
// blocks the operation of the same cycle.
module colmarch_seq
    import colmarch_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     ag_addr,
    input  logic              ag_last,
    input  logic              mismatch,
    input  logic [AW-1:0]     mis_addr,
    input  logic [ELEM_W-1:0] mis_elem,
    output logic              ag_load,
    output logic              ag_step,
    output logic              ld_down,
    output flt_e              ld_flt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              rd_issue,
    output logic              rd_exp,
    output logic [ELEM_W-1:0] cur_elem,
    output logic              done,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} st_e;

    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEMS - 1);

    st_e               state_q;
    logic [ELEM_W-1:0] elem_q;
    logic              opi_q;
    logic              fail_q;
    logic [AW-1:0]     fail_addr_q;
    logic [ELEM_W-1:0] fail_elem_q;

    elem_t             desc;
    elem_t             nxt_desc;
    op_e               cur_op;
    logic              issue;
    logic              adv;

    // Decode the active element and the operation of this cycle
    always_comb begin
        desc     = elem_rom(elem_q);
        nxt_desc = elem_rom(elem_q + ELEM_W'(1));
        cur_op   = opi_q ? desc.op_b : desc.op_a;
        issue    = (state_q == ST_RUN) && !mismatch;
        adv      = !(desc.two && !opi_q);
    end

    // Memory drive and read hand-off to the comparator
    always_comb begin
        mem_en    = issue;
        mem_we    = issue && !op_is_rd(cur_op);
        mem_wdata = {DW{op_val(cur_op)}};
        rd_issue  = issue && op_is_rd(cur_op);
        rd_exp    = op_val(cur_op);
        cur_elem  = elem_q;
    end

    // Address generator control: load on entry to an element, step inside it
    always_comb begin
        ag_load = 1'b0;
        ag_step = 1'b0;
        ld_down = desc.down;
        ld_flt  = desc.flt;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ag_load = 1'b1;
                    ld_down = elem_rom('0).down;
                    ld_flt  = elem_rom('0).flt;
                end
            end
            ST_RUN: begin
                if (!mismatch && adv) begin
                    if (!ag_last) begin
                        ag_step = 1'b1;
                    end else if (elem_q != LAST_ELEM) begin
                        ag_load = 1'b1;
                        ld_down = nxt_desc.down;
                        ld_flt  = nxt_desc.flt;
                    end
                end
            end
            default: ;
        endcase
    end

    // Sequencer state, element/op counters and failure record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            elem_q      <= '0;
            opi_q       <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            fail_elem_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q     <= ST_RUN;
                        elem_q      <= '0;
                        opi_q       <= 1'b0;
                        fail_q      <= 1'b0;
                        fail_addr_q <= '0;
                        fail_elem_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (mismatch) begin
                        state_q     <= ST_DONE;
                        fail_q      <= 1'b1;
                        fail_addr_q <= mis_addr;
                        fail_elem_q <= mis_elem;
                    end else if (!adv) begin
                        opi_q <= 1'b1;
                    end else begin
                        opi_q <= 1'b0;
                        if (ag_last) begin
                            if (elem_q == LAST_ELEM) begin
                                state_q <= ST_DRAIN;
                            end else begin
                                elem_q <= elem_q + ELEM_W'(1);
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    state_q <= ST_DONE;
                    if (mismatch) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= mis_addr;
                        fail_elem_q <= mis_elem;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result outputs
    always_comb begin
        done      = (state_q == ST_DONE);
        fail      = fail_q;
        fail_addr = fail_addr_q;
        fail_elem = fail_elem_q;
    end

    // A reported mismatch ends the test with fail on the next edge
    p_mis_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (state_q == ST_DONE) && fail_q);

    // Fail is only ever seen together with a finished test
    p_fail_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> (state_q == ST_DONE));

    // Start while running never rewinds the element counter
    p_no_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && start) |=> (elem_q >= $past(elem_q)));

    // A finished result holds until the next start
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE) && !start) |=>
            ((state_q == ST_DONE) && $stable(fail_q) && $stable(fail_addr_q)
             && $stable(fail_elem_q)));

    // Even-column elements only present even column addresses
    p_even_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (desc.flt == FLT_EVEN || desc.flt == FLT_EVEN_IN)) |-> !ag_addr[0]);

    // Odd-column elements only present odd column addresses
    p_odd_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (desc.flt == FLT_ODD || desc.flt == FLT_ODD_IN)) |-> ag_addr[0]);

endmodule

// File: rtl/colmarch_bist.sv
`timescale 1ns/1ps
// colmarch_bist: top of the column-aware March self-test engine. Ties the
// sequencer, the filtered address generator and the read comparator.
// Assumes: single-port synchronous SRAM with one-cycle read latency;
// ROWS >= 2 and COLS >= 4, both powers of two.
module colmarch_bist
    import colmarch_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(ROWS) + $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              done,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    logic              ag_load;
    logic              ag_step;
    logic              ld_down;
    flt_e              ld_flt;
    logic [AW-1:0]     ag_addr;
    logic              ag_last;
    logic              rd_issue;
    logic              rd_exp;
    logic [ELEM_W-1:0] cur_elem;
    logic              mismatch;
    logic [AW-1:0]     mis_addr;
    logic [ELEM_W-1:0] mis_elem;

    colmarch_addr_gen #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_agen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ag_load),
        .step    (ag_step),
        .ld_down (ld_down),
        .ld_flt  (ld_flt),
        .addr    (ag_addr),
        .last    (ag_last)
    );

    colmarch_cmp #(
        .DW (DW),
        .AW (AW)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .rd_exp   (rd_exp),
        .rd_addr  (ag_addr),
        .rd_elem  (cur_elem),
        .rdata    (mem_rdata),
        .mismatch (mismatch),
        .mis_addr (mis_addr),
        .mis_elem (mis_elem)
    );

    colmarch_seq #(
        .DW (DW),
        .AW (AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ag_addr   (ag_addr),
        .ag_last   (ag_last),
        .mismatch  (mismatch),
        .mis_addr  (mis_addr),
        .mis_elem  (mis_elem),
        .ag_load   (ag_load),
        .ag_step   (ag_step),
        .ld_down   (ld_down),
        .ld_flt    (ld_flt),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rd_issue  (rd_issue),
        .rd_exp    (rd_exp),
        .cur_elem  (cur_elem),
        .done      (done),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem)
    );

    // Address output straight from the generator
    always_comb mem_addr = ag_addr;

    // No memory traffic while a result is on display
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_en);

    // Write words are uniform
    p_wdata_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata == '0) || (mem_wdata == '1)));

endmodule

// File: tb/colmarch_bist_tb_top.sv
`timescale 1ns/1ps
// colmarch_bist_tb_top: self-checking bench. Behavioural SRAM with an
// injectable fault, a reference walk of the element table, directed and
// seeded random fault runs.
module colmarch_bist_tb_top;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int DW   = 8;
    localparam int N    = ROWS * COLS;
    localparam int M    = 12 * N - 2 * ROWS;
    localparam int AW   = $clog2(N);
    localparam int LIM  = 4 * M;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [DW-1:0] mem_rdata;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          done;
    logic          fail;
    logic [AW-1:0] fail_addr;
    logic [3:0]    fail_elem;

    always #2.5 clk = ~clk;

    colmarch_bist #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_elem(fail_elem)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Fault: 0 none, 1 stuck 0, 2 stuck 1, 3 neighbour write-1 sets victim,
    // 4 neighbour write-1 clears victim. Active from op number `arm`.
    int ftype = 0;
    int victim = 0;
    int arm = 0;

    function automatic logic [DW-1:0] obs_read(int a, logic [DW-1:0] s, int n);
        if (n >= arm && a == victim && ftype == 1) return '0;
        if (n >= arm && a == victim && ftype == 2) return '1;
        return s;
    endfunction

    function automatic int dist_kind(int a, logic [DW-1:0] d, int n);
        if (n >= arm && a == (victim ^ 1) && d != '0) begin
            if (ftype == 3) return 1;
            if (ftype == 4) return 2;
        end
        return 0;
    endfunction

    // Memory model with operation trace
    logic [DW-1:0] cells [N];
    int            op_cnt;
    logic          clr_mem = 1'b0;
    logic [AW-1:0] tr_addr [M];
    logic          tr_we [M];
    logic [DW-1:0] tr_wd [M];

    always @(posedge clk) begin
        int dk;
        if (clr_mem) begin
            for (int i = 0; i < N; i++) cells[i] = DW'(8'hA5);
            op_cnt = 0;
        end else if (mem_en) begin
            if (op_cnt < M) begin
                tr_addr[op_cnt] = mem_addr;
                tr_we[op_cnt]   = mem_we;
                tr_wd[op_cnt]   = mem_wdata;
            end
            if (mem_we) begin
                cells[mem_addr] = mem_wdata;
                dk = dist_kind(int'(mem_addr), mem_wdata, op_cnt);
                if (dk == 1) cells[victim] = '1;
                else if (dk == 2) cells[victim] = '0;
            end else begin
                mem_rdata <= obs_read(int'(mem_addr), cells[mem_addr], op_cnt);
            end
            op_cnt = op_cnt + 1;
        end
    end

    // Reference walk of the element table (R2, R3)
    logic [DW-1:0] rcells [N];
    logic [AW-1:0] x_addr [M];
    logic          x_we [M];
    logic [DW-1:0] x_wd [M];
    int            e_ops;
    bit            e_fail;
    int            e_addr;
    int            e_elem;

    function automatic bit in_filt(int a, int f);
        int c;
        c = a % COLS;
        case (f)
            1: return (c % 2) == 0;
            2: return (c % 2) == 1;
            3: return (c % 2) == 0 && c != 0;
            4: return (c % 2) == 1 && c != COLS - 1;
            default: return 1'b1;
        endcase
    endfunction

    // ops: 0 W0, 1 W1, 2 R0, 3 R1; filters: 0 all, 1 even, 2 odd,
    // 3 even without col 0, 4 odd without last col
    task automatic el(int e, output bit dn, output int f, output int nop,
                      output int o0, output int o1);
        dn = 0; f = 0; nop = 2; o0 = 0; o1 = 0;
        case (e)
            0: begin nop = 1; o0 = 0; end
            1: begin o0 = 2; o1 = 1; end
            2: begin o0 = 3; o1 = 0; end
            3: begin dn = 1; o0 = 2; o1 = 1; end
            4: begin dn = 1; o0 = 3; o1 = 0; end
            5: begin f = 1; o0 = 1; o1 = 3; end
            6: begin f = 4; nop = 1; o0 = 2; end
            7: begin f = 2; o0 = 1; o1 = 3; end
            default: begin f = 3; nop = 1; o0 = 3; end
        endcase
    endtask

    task automatic ref_run();
        bit dn;
        int f, nop, o0, o1, a, op, dk;
        logic [DW-1:0] v;
        for (int i = 0; i < N; i++) rcells[i] = DW'(8'hA5);
        e_ops = 0; e_fail = 0; e_addr = 0; e_elem = 0;
        for (int e = 0; e < 9 && !e_fail; e++) begin
            el(e, dn, f, nop, o0, o1);
            for (int s = 0; s < N && !e_fail; s++) begin
                a = dn ? N - 1 - s : s;
                if (in_filt(a, f)) begin
                    for (int p = 0; p < nop && !e_fail; p++) begin
                        op = (p == 0) ? o0 : o1;
                        v  = (op % 2 == 1) ? '1 : '0;
                        if (e_ops < M) begin
                            x_addr[e_ops] = AW'(a);
                            x_we[e_ops]   = (op < 2);
                            x_wd[e_ops]   = v;
                        end
                        if (op < 2) begin
                            rcells[a] = v;
                            dk = dist_kind(a, v, e_ops);
                            if (dk == 1) rcells[victim] = '1;
                            else if (dk == 2) rcells[victim] = '0;
                        end else if (obs_read(a, rcells[a], e_ops) != v) begin
                            e_fail = 1; e_addr = a; e_elem = e;
                        end
                        e_ops++;
                    end
                end
            end
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One full test: start, count edges to done, compare with reference
    task automatic do_run(string rq, int poke_at);
        int lat, mm, nonuni;
        ref_run();
        @(negedge clk); clr_mem = 1'b1;
        @(negedge clk); clr_mem = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done && lat < LIM) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (lat == poke_at);
        end
        start = 1'b0;
        chk(done, rq, "watchdog: done seen", int'(done), 1);
        chk(fail == e_fail, rq, "fail", int'(fail), int'(e_fail));
        chk(op_cnt == e_ops, rq, "operation count", op_cnt, e_ops);
        chk(lat == e_ops + 1, "R5 R6", "edges start to done", lat, e_ops + 1);
        if (e_fail) begin
            chk(int'(fail_addr) == e_addr, "R6", "fail_addr", int'(fail_addr), e_addr);
            chk(int'(fail_elem) == e_elem, "R6", "fail_elem", int'(fail_elem), e_elem);
        end
        mm = 0; nonuni = 0;
        for (int i = 0; i < e_ops && i < M; i++) begin
            if (tr_addr[i] !== x_addr[i] || tr_we[i] !== x_we[i]) mm++;
            if (tr_we[i] && tr_wd[i] !== x_wd[i]) nonuni++;
        end
        chk(mm == 0, "R2 R3", "trace address/direction mismatches", mm, 0);
        chk(nonuni == 0, "R9", "write data mismatches", nonuni, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int junk, hold_ok;
        logic [AW-1:0] fa;
        junk = $urandom(32'd20517);
        rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_en && !done && !fail, "R1", "idle outputs after reset",
            int'({mem_en, done, fail}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_en, "R1", "no traffic before start", int'(mem_en), 0);

        // R4: clean run, count equals 12N-2R
        ftype = 0;
        do_run("R4", -1);
        chk(op_cnt == M, "R4", "formula count", op_cnt, M);

        // R10: result holds without start
        fa = fail_addr; hold_ok = 1;
        repeat (6) begin
            @(negedge clk);
            if (!done || fail || fail_addr != fa || mem_en) hold_ok = 0;
        end
        chk(hold_ok == 1, "R10", "done/fail hold", hold_ok, 1);

        // R6: stuck-0 on the last inner even cell, found by the very last read
        ftype = 1; victim = (ROWS - 1) * COLS + COLS - 2; arm = M - (N / 2 - ROWS);
        do_run("R6", -1);
        chk(fail_elem == 4'd8 && op_cnt == M, "R6", "last-op failure elem",
            int'(fail_elem), 8);

        // R8: restart after a failure clears fail
        ftype = 0;
        do_run("R8", -1);
        chk(!fail && fail_addr == '0 && fail_elem == '0, "R8", "cleared result",
            int'(fail), 0);

        // R6: stuck-1 at address 0 from time zero, seen by element 1
        ftype = 2; victim = 0; arm = 0;
        do_run("R6", -1);
        chk(fail_elem == 4'd1, "R6", "stuck-1 element", int'(fail_elem), 1);

        // R6: half-select disturb armed at element 5, seen by element 6
        ftype = 3; victim = 2 * COLS + 3; arm = 9 * N;
        do_run("R6", -1);
        chk(fail_elem == 4'd6, "R6", "disturb element", int'(fail_elem), 6);

        // R6: half-select clear armed at element 7, seen by element 8
        ftype = 4; victim = 3 * COLS + 4; arm = 9 * N + N + (N / 2 - ROWS);
        do_run("R6", -1);
        chk(fail_elem == 4'd8, "R6", "clear disturb element", int'(fail_elem), 8);

        // R7: start pulses while running change nothing
        ftype = 0;
        do_run("R7", 37);
        chk(op_cnt == M && !fail, "R7", "count with mid-run start", op_cnt, M);

        // Seeded random faults
        for (int t = 0; t < 10; t++) begin
            ftype  = int'($urandom % 5);
            victim = int'($urandom % N);
            arm    = int'($urandom % M);
            do_run((ftype == 0) ? "R4" : "R6", -1);
        end

        // R1: reset in the middle of a run
        ftype = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_en && !done && !fail, "R1", "outputs after mid-run reset",
            int'({mem_en, done, fail}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!mem_en && !done, "R1", "stays idle after reset",
            int'({mem_en, done}), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule